// File: doc/BRIEF.md
# Bidirectional Parallel Port Controller

This block is a register-mapped controller for a bidirectional printer port. A host reaches it through a simple register bus: an offset address, separate read and write strobes, and 8-bit write and read data. Inside are a data register, a read-only status view of the printer-side inputs, a control register and a one-bit interrupt flag. On the pin side it drives eight data lines with a shared output enable. It drives four active-low control lines in open-drain fashion, each with its own drive-low enable, and it reads back the actual level of each line. It also samples five printer-side inputs.

A rising edge on the acknowledge input goes through a two-flop synchronizer and an edge detector. When the interrupt enable is set, that edge latches a sticky interrupt flag. The flag drives the `irq` output and stays set until software writes 0 to it. Read data is registered: a read strobe captures the addressed value, and `rdata` holds it until the next read.

Top module: `lpt_port_ctrl`

## Requirements
- R1: After reset every register holds 00h. This means `pd_oe`=1, `pd_out`=00h, `strobe_n_lo`/`afd_n_lo`/`slctin_n_lo`=0, `init_n_lo`=1 and `irq`=0. A control read returns 00h while the lines follow the drives.
- R2: With the direction bit (control bit 5) at 0, a write to offset 0 puts the byte on `pd_out` from the clock edge that takes the write, and `pd_oe` is 1.
- R3: With control bit 5 at 1, `pd_oe` is 0 and a write to offset 0 is discarded. After bit 5 returns to 0, `pd_out` shows the last byte written in output mode.
- R4: A read of offset 0 returns the live `pd_in` value in either direction.
- R5: A read of offset 2 returns, from bit 7 down to bit 3: the inverse of `busy_in`, `ack_n_in`, `pe_in`, `slct_in` and `err_n_in`. Bits 2..0 read 0.
- R6: Control bits 0, 1 and 3 drive `strobe_n_lo`, `afd_n_lo` and `slctin_n_lo`. Writing 1 enables the drive-low and writing 0 floats the line. A read of the bit returns the inverse of the line level (`strobe_n_in`, `afd_n_in`, `slctin_n_in`).
- R7: Control bit 2 has the reverse sense. Writing 0 sets `init_n_lo`=1 and writing 1 floats the line. A read returns `init_n_in` without inversion.
- R8: Control bits 4 (interrupt enable), 5 (direction) and 6 (enhanced mode select) read back as written. Bit 7 reads 0.
- R9: A 0-to-1 change of `ack_n_in` sets `irq` on the third rising clock edge after the change, provided control bit 4 is 1. With bit 4 at 0 the same change leaves `irq` at 0.
- R10: Offset 6 bit 0 reads the interrupt flag and bits 7..1 read 0. Writing 0 to bit 0 clears the flag, and writing 1 leaves it unchanged.
- R11: `rdata` takes the addressed value at the edge where `rd_en` is 1 and keeps it while `rd_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Register offset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| pd_in | input | 8 | Data line levels |
| pd_out | output | 8 | Data line drive value |
| pd_oe | output | 1 | Data line output enable |
| strobe_n_in | input | 1 | Strobe line level |
| strobe_n_lo | output | 1 | Strobe drive-low enable |
| afd_n_in | input | 1 | Auto-feed line level |
| afd_n_lo | output | 1 | Auto-feed drive-low enable |
| init_n_in | input | 1 | Init line level |
| init_n_lo | output | 1 | Init drive-low enable |
| slctin_n_in | input | 1 | Select-in line level |
| slctin_n_lo | output | 1 | Select-in drive-low enable |
| err_n_in | input | 1 | Printer error, active low |
| slct_in | input | 1 | Printer selected |
| pe_in | input | 1 | Paper empty |
| ack_n_in | input | 1 | Acknowledge, active low |
| busy_in | input | 1 | Printer busy |
| irq | output | 1 | Sticky interrupt request |

## Verification
A corrupted control register shows at once on the drive-low enables and `pd_oe` in the cycle after the write. It also shows in the very next control read, because that read goes back through the line levels. If the data register takes a write in input mode, nothing shows until direction returns to output, so the bench flips direction and compares `pd_out`. Errors in the synchronizer or flag show as `irq` asserting one cycle early or late against the three-edge latency, or as a flag that survives a clear or is lost on a write of 1.

// File: rtl/lpt_pkg.sv
package lpt_pkg;

    localparam int DW = 8;

    localparam int OFF_DATA = 0;
    localparam int OFF_STAT = 2;
    localparam int OFF_CTRL = 4;
    localparam int OFF_IRQ  = 6;

    // control register layout, bit 6 down to bit 0
    typedef struct packed {
        logic enh;        // enhanced mode select
        logic dir;        // 1 = input
        logic ie;         // interrupt enable
        logic slctin_lo;  // 1 = drive low
        logic init_rel;   // 1 = float, 0 = drive low
        logic afd_lo;     // 1 = drive low
        logic strobe_lo;  // 1 = drive low
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    function automatic logic [DW-1:0] pack_status(
        input logic err_n, input logic slct, input logic pe,
        input logic ack_n, input logic busy);
        return {~busy, ack_n, pe, slct, err_n, 3'b000};
    endfunction

    function automatic logic [DW-1:0] pack_ctrl_rd(
        input ctrl_t c, input logic strobe_n, input logic afd_n,
        input logic init_n, input logic slctin_n);
        return {1'b0, c.enh, c.dir, c.ie, ~slctin_n, init_n, ~afd_n, ~strobe_n};
    endfunction

endpackage

// File: rtl/lpt_ack_edge.sv
module lpt_ack_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ack_n_in,
    output logic rise
);
    logic [STAGES-1:0] sq;
    logic              prev;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sq <= '1;
                else     sq <= ack_n_in;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) sq <= '1;
                else     sq <= {sq[STAGES-2:0], ack_n_in};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b1;
        else     prev <= sq[STAGES-1];
    end

    assign rise = sq[STAGES-1] & ~prev;

    // R9
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);

endmodule

// File: rtl/lpt_irq_flag.sv
module lpt_irq_flag (
    input  logic clk,
    input  logic rst,
    input  logic rise,
    input  logic ie,
    input  logic clr,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst) flag <= 1'b0;
        else     flag <= (flag & ~clr) | (rise & ie);
    end

    // R10
    clear_takes_chk: assert property (@(posedge clk) disable iff (rst)
        (clr && !ie) |=> !flag);

endmodule

// File: rtl/lpt_regs.sv
module lpt_regs
    import lpt_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_data,
    input  logic          wr_ctrl,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] data_q,
    output ctrl_t         ctrl_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            ctrl_q <= '0;
        end else begin
            if (wr_ctrl)
                ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
            if (wr_data && !ctrl_q.dir)
                data_q <= wdata;
        end
    end

    // R3
    input_mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_data && ctrl_q.dir && !wr_ctrl) |=> $stable(data_q));

endmodule

// File: rtl/lpt_port_ctrl.sv
module lpt_port_ctrl
    import lpt_pkg::*;
#(
    parameter int ADDR_W      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic [7:0]        pd_in,
    output logic [7:0]        pd_out,
    output logic              pd_oe,
    input  logic              strobe_n_in,
    output logic              strobe_n_lo,
    input  logic              afd_n_in,
    output logic              afd_n_lo,
    input  logic              init_n_in,
    output logic              init_n_lo,
    input  logic              slctin_n_in,
    output logic              slctin_n_lo,
    input  logic              err_n_in,
    input  logic              slct_in,
    input  logic              pe_in,
    input  logic              ack_n_in,
    input  logic              busy_in,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFF_DATA);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
    localparam logic [ADDR_W-1:0] A_IRQ  = ADDR_W'(OFF_IRQ);

    ctrl_t         ctrl;
    logic [DW-1:0] data_q;
    logic [DW-1:0] rd_mux;
    logic          ack_rise;
    logic          irq_clr;

    lpt_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_data (wr_en && addr == A_DATA),
        .wr_ctrl (wr_en && addr == A_CTRL),
        .wdata   (wdata),
        .data_q  (data_q),
        .ctrl_q  (ctrl)
    );

    lpt_ack_edge #(.STAGES(SYNC_STAGES)) u_ack (
        .clk      (clk),
        .rst      (rst),
        .ack_n_in (ack_n_in),
        .rise     (ack_rise)
    );

    assign irq_clr = wr_en && (addr == A_IRQ) && !wdata[0];

    lpt_irq_flag u_irq (
        .clk  (clk),
        .rst  (rst),
        .rise (ack_rise),
        .ie   (ctrl.ie),
        .clr  (irq_clr),
        .flag (irq)
    );

    assign pd_out      = data_q;
    assign pd_oe       = ~ctrl.dir;
    assign strobe_n_lo = ctrl.strobe_lo;
    assign afd_n_lo    = ctrl.afd_lo;
    assign slctin_n_lo = ctrl.slctin_lo;
    assign init_n_lo   = ~ctrl.init_rel;

    always_comb begin
        case (addr)
            A_DATA:  rd_mux = pd_in;
            A_STAT:  rd_mux = pack_status(err_n_in, slct_in, pe_in, ack_n_in, busy_in);
            A_CTRL:  rd_mux = pack_ctrl_rd(ctrl, strobe_n_in, afd_n_in, init_n_in, slctin_n_in);
            A_IRQ:   rd_mux = {7'b0, irq};
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata <= '0;
        else if (rd_en) rdata <= rd_mux;
    end

    // R6
    strobe_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_CTRL) |=> strobe_n_lo == $past(wdata[0]));
    // R7
    init_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_CTRL) |=> init_n_lo == !$past(wdata[2]));
    // R9
    irq_needs_ie_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(ctrl.ie));
    // R10
    irq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (irq && !irq_clr) |=> irq);
    // R5
    stat_low_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == A_STAT) |=> rdata[2:0] == 3'b000);
    // R11
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata));

endmodule

// File: tb/lpt_port_ctrl_tb.sv
`timescale 1ns/1ps
module lpt_port_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] addr = '0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wdata = '0, rdata, pd_in = '0, pd_out;
    logic       pd_oe;
    logic       strobe_n_lo, afd_n_lo, init_n_lo, slctin_n_lo;
    logic       ext_strobe = 1'b1, ext_init = 1'b1;
    logic       err_n_in = 1'b1, slct_in = 1'b0, pe_in = 1'b0;
    logic       ack_n_in = 1'b1, busy_in = 1'b0;
    logic       irq;
    logic       strobe_n_in, afd_n_in, init_n_in, slctin_n_in;

    // pulled-up open-drain lines
    assign strobe_n_in = strobe_n_lo ? 1'b0 : ext_strobe;
    assign afd_n_in    = afd_n_lo    ? 1'b0 : 1'b1;
    assign init_n_in   = init_n_lo   ? 1'b0 : ext_init;
    assign slctin_n_in = slctin_n_lo ? 1'b0 : 1'b1;

    always #2.5 clk = ~clk;

    lpt_port_ctrl u_dut (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .pd_in(pd_in), .pd_out(pd_out),
        .pd_oe(pd_oe), .strobe_n_in(strobe_n_in), .strobe_n_lo(strobe_n_lo),
        .afd_n_in(afd_n_in), .afd_n_lo(afd_n_lo), .init_n_in(init_n_in),
        .init_n_lo(init_n_lo), .slctin_n_in(slctin_n_in),
        .slctin_n_lo(slctin_n_lo), .err_n_in(err_n_in), .slct_in(slct_in),
        .pe_in(pe_in), .ack_n_in(ack_n_in), .busy_in(busy_in), .irq(irq)
    );

    int n_vec = 0, n_bad = 0;
    bit done = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       rd_d = 1'b0;

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // monitor: compares registered read data one cycle after the strobe
    always @(posedge clk) rd_d <= rd_en;
    always @(negedge clk) begin
        if (rd_d && exp_q.size() > 0) begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(rdata, e, t);
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [7:0] e, input string tag);
        @(negedge clk); addr = a; rd_en = 1'b1;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk); rd_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk({7'b0, pd_oe}, 8'h01, "R1 pd_oe");
        chk(pd_out, 8'h00, "R1 pd_out");
        chk({4'b0, strobe_n_lo, afd_n_lo, slctin_n_lo, init_n_lo}, 8'h01, "R1 drives");
        chk({7'b0, irq}, 8'h00, "R1 irq");
        rd(3'd4, 8'h00, "R1 ctrl");
        rd(3'd6, 8'h00, "R1 irqreg");

        // R2 output mode write
        wr(3'd0, 8'hA5);
        chk(pd_out, 8'hA5, "R2 pd_out");
        chk({7'b0, pd_oe}, 8'h01, "R2 pd_oe");
        pd_in = 8'h3C;
        rd(3'd0, 8'h3C, "R4 out mode");

        // R3 input mode
        wr(3'd4, 8'h20);
        chk({7'b0, pd_oe}, 8'h00, "R3 pd_oe");
        wr(3'd0, 8'h5A);
        pd_in = 8'hC3;
        rd(3'd0, 8'hC3, "R4 in mode");
        wr(3'd4, 8'h00);
        chk(pd_out, 8'hA5, "R3 ignored write");

        // R5 status
        err_n_in = 1; slct_in = 0; pe_in = 1; ack_n_in = 1; busy_in = 0;
        rd(3'd2, 8'hE8, "R5 pattern a");
        err_n_in = 0; slct_in = 1; pe_in = 0; ack_n_in = 0; busy_in = 1;
        rd(3'd2, 8'h10, "R5 pattern b");
        // R9 rising ack with ie=0 must not set
        @(negedge clk); ack_n_in = 1;
        repeat (5) @(negedge clk);
        chk({7'b0, irq}, 8'h00, "R9 ie off");

        // R6 / R7 control lines
        wr(3'd4, 8'h0B);
        chk({4'b0, strobe_n_lo, afd_n_lo, slctin_n_lo, init_n_lo}, 8'h0F, "R6 drives on");
        rd(3'd4, 8'h0B, "R6 readback driven");
        wr(3'd4, 8'h04);
        chk({4'b0, strobe_n_lo, afd_n_lo, slctin_n_lo, init_n_lo}, 8'h00, "R7 released");
        rd(3'd4, 8'h04, "R7 readback");
        ext_strobe = 0; ext_init = 0;
        rd(3'd4, 8'h01, "R6 R7 external low");
        ext_strobe = 1; ext_init = 1;

        // R8
        wr(3'd4, 8'h74);
        rd(3'd4, 8'h74, "R8 mode bits");
        wr(3'd4, 8'hF4);
        rd(3'd4, 8'h74, "R8 bit7 zero");

        // R9 latency with ie=1
        wr(3'd4, 8'h14);
        @(negedge clk); ack_n_in = 0;
        repeat (3) @(negedge clk);
        ack_n_in = 1;
        @(negedge clk);
        @(negedge clk);
        chk({7'b0, irq}, 8'h00, "R9 not yet");
        @(negedge clk);
        chk({7'b0, irq}, 8'h01, "R9 set");

        // R10
        rd(3'd6, 8'h01, "R10 read");
        wr(3'd6, 8'h01);
        chk({7'b0, irq}, 8'h01, "R10 write one");
        wr(3'd6, 8'hFE);
        chk({7'b0, irq}, 8'h00, "R10 clear");
        rd(3'd6, 8'h00, "R10 read cleared");

        // R11 hold
        err_n_in = 1; slct_in = 1; pe_in = 1; ack_n_in = 1; busy_in = 0;
        rd(3'd2, 8'hF8, "R11 capture");
        busy_in = 1; pe_in = 0;
        repeat (3) @(negedge clk);
        chk(rdata, 8'hF8, "R11 hold");

        repeat (2) @(negedge clk);
        if (exp_q.size() != 0) chk(8'(exp_q.size()), 8'h00, "R11 pending reads");
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule